// File: doc/BRIEF.md
# Synchronized Clock Output Divider Channel

One output lane of a clock distribution fabric. The whole lane runs on the high-speed distribution clock. Each lane can do one of two things. It can pass that clock straight through (bypass), or it can divide it by an even ratio that is set by an 8-bit code. A lane's output is visible only while three enables agree: the per-lane enable bit, a fabric-wide enable bit and an output-enable pin. A power-down control overrides all of them.

Several lanes share one active-low synchronisation input. A sync request holds every divided lane low. Releasing it makes all divided lanes start their first high phase on the same distribution-clock edge, so lanes with different ratios stay phase aligned. Bypassed lanes ignore sync. A delay-select bit in the mode field is carried for the analog delay stage, which lies outside this block. It has no effect on digital timing.

Top module: `sync_div_channel`

## Requirements
- R1: In a bypass mode (mode 0 or 2) with the output enabled, `ch_out` follows `dist_clk` (high in the high phase, low in the low phase), whatever the state of `sync_n`.
- R2: In a divided mode, with code C from 1 to 255, the output has period 2*C distribution cycles. It is high for C cycles and then low for C cycles, and the high phase comes first after each start.
- R3: A code of 0 divides exactly as a code of 1 does: one cycle high, one cycle low.
- R4: Bit 0 of `cfg_mode` selects the divider. Modes 1 and 3 divide and modes 0 and 2 bypass. Bit 1 (delay select) changes nothing at the output.
- R5: A sync request is recognised only when `sync_n` is sampled low at two consecutive rising edges. A single-edge low pulse leaves the divided output untouched.
- R6: After a sync request is recognised on an edge, the divided output is low from the fourth edge after it onward. It stays low for as long as `sync_n` stays low.
- R7: When `sync_n` is sampled high after a recognised request, the divided output goes high on the fourth edge after that sample, with its counter at the start of the high phase.
- R8: `ch_out` is 0 unless `cfg_en`, `glob_en` and `oe_pin` are all 1.
- R9: While `pwr_down` is 1, `ch_out` is 0 regardless of every other input.
- R10: While the lane is disabled or in reset, the divider is held at its start phase. On the first edge after it becomes enabled in a divided mode, the output starts a full high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dist_clk | input | 1 | Distribution clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Lane mode: bit 0 divide, bit 1 delay select |
| cfg_en | input | 1 | Per-lane output enable bit |
| cfg_code | input | CODE_W | Divider code; ratio is twice the code |
| sync_n | input | 1 | Shared active-low synchronisation request |
| glob_en | input | 1 | Fabric-wide enable bit |
| oe_pin | input | 1 | Output-enable pin |
| pwr_down | input | 1 | Power-down control, overrides all others |
| ch_out | output | 1 | Lane clock output |

## Verification
The bench targets the sync latency in both directions. If the delay line is one stage short or long, the divided output falls or rises one edge early or late. If the recogniser takes a single low sample, a one-edge glitch on `sync_n` would stop the divider. Code 0 is tested on its own, because a design that forgot the remap would load a zero half-period and stick high or low. Re-enabling after every one of the four disables checks that the divider restarts with a high phase, and does not resume a stale count mid-period.

// File: rtl/sync_div_pkg.sv
package sync_div_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS  = 2'd0,
    MODE_DIV     = 2'd1,
    MODE_DLY     = 2'd2,
    MODE_DIV_DLY = 2'd3
  } chan_mode_e;

  // Divider path is selected by the low mode bit alone.
  function automatic logic mode_divides(input logic [1:0] m);
    return m[0];
  endfunction

endpackage

// File: rtl/sync_align.sv
module sync_align #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  output logic sync_q,
  output logic sync_held,
  output logic hold_eff
);
  localparam int STAGES = LAT - 1;

  logic [STAGES-1:0] dly;

  // Request is held after two consecutive low samples, dropped on a high sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 1'b1;
      sync_held <= 1'b0;
    end else begin
      sync_q <= sync_n;
      if (sync_n)
        sync_held <= 1'b0;
      else if (!sync_q)
        sync_held <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) dly[0] <= 1'b0;
          else        dly[0] <= sync_held;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) dly[i] <= 1'b0;
          else        dly[i] <= dly[i-1];
        end
      end
    end
  endgenerate

  assign hold_eff = dly[STAGES-1];

endmodule

// File: rtl/half_rate_div.sv
module half_rate_div #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CODE_W-1:0] code,
  output logic              running,
  output logic [CODE_W:0]   count,
  output logic [CODE_W:0]   last,
  output logic              level
);
  localparam int CNT_W = CODE_W + 1;

  function automatic logic [CNT_W-1:0] half_len(input logic [CODE_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : CNT_W'(c);
  endfunction

  function automatic logic [CNT_W-1:0] period_end(input logic [CNT_W-1:0] h);
    return (h << 1) - CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] half;

  assign half = half_len(code);
  assign last = period_end(half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      count   <= '0;
    end else if (!go) begin
      running <= 1'b0;
      count   <= '0;
    end else if (!running) begin
      running <= 1'b1;
      count   <= '0;
    end else if (count >= last) begin
      count <= '0;
    end else begin
      count <= count + CNT_W'(1);
    end
  end

  assign level = running && (count < half);

endmodule

// File: rtl/out_gate.sv
module out_gate (
  input  logic clk,
  input  logic en_all,
  input  logic divides,
  input  logic div_level,
  output logic out
);
  always_comb begin
    if (!en_all)      out = 1'b0;
    else if (divides) out = div_level;
    else              out = clk;
  end
endmodule

// File: rtl/sync_div_channel.sv
module sync_div_channel
  import sync_div_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int SYNC_LAT = 4
) (
  input  logic              dist_clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_en,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              sync_n,
  input  logic              glob_en,
  input  logic              oe_pin,
  input  logic              pwr_down,
  output logic              ch_out
);
  localparam int CNT_W = CODE_W + 1;

  logic             sync_q, sync_held, hold_eff;
  logic             en_all, divides, div_go;
  logic             run;
  logic [CNT_W-1:0] cnt, last;
  logic             div_level;

  assign en_all  = cfg_en & glob_en & oe_pin & ~pwr_down;
  assign divides = mode_divides(cfg_mode);
  assign div_go  = en_all & divides & ~hold_eff;

  sync_align #(.LAT(SYNC_LAT)) u_sync (
    .clk       (dist_clk),
    .rst_n     (rst_n),
    .sync_n    (sync_n),
    .sync_q    (sync_q),
    .sync_held (sync_held),
    .hold_eff  (hold_eff)
  );

  half_rate_div #(.CODE_W(CODE_W)) u_div (
    .clk     (dist_clk),
    .rst_n   (rst_n),
    .go      (div_go),
    .code    (cfg_code),
    .running (run),
    .count   (cnt),
    .last    (last),
    .level   (div_level)
  );

  out_gate u_gate (
    .clk       (dist_clk),
    .en_all    (en_all),
    .divides   (divides),
    .div_level (div_level),
    .out       (ch_out)
  );

endmodule

// File: rtl/sync_div_channel_chk.sv
module sync_div_channel_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_n,
  input logic             sync_q,
  input logic             sync_held,
  input logic             hold_eff,
  input logic             en_all,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] last
);
  assert_recognise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n && !sync_q) |=> sync_held);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |=> !sync_held);

  assert_hold_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_eff |=> !run);

  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_all |=> !run);

  assert_start_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt >= last) |=> (cnt == '0));
endmodule

bind sync_div_channel sync_div_channel_chk #(.CNT_W(CODE_W + 1)) chk_i (
  .clk       (dist_clk),
  .rst_n     (rst_n),
  .sync_n    (sync_n),
  .sync_q    (sync_q),
  .sync_held (sync_held),
  .hold_eff  (hold_eff),
  .en_all    (en_all),
  .run       (run),
  .cnt       (cnt),
  .last      (last)
);

// File: tb/sync_div_channel_tb_top.sv
`timescale 1ns/1ps
module sync_div_channel_tb_top;
  logic       dist_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_en = 1'b0;
  logic [7:0] cfg_code = 8'd1;
  logic       sync_n = 1'b1;
  logic       glob_en = 1'b1;
  logic       oe_pin = 1'b1;
  logic       pwr_down = 1'b0;
  logic       ch_out;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  string tag = "R10";

  // bench model state
  bit m_prev_sync = 1;
  bit m_hist[4];
  bit m_run = 0;
  int m_cnt = 0;

  always #10 dist_clk = ~dist_clk;

  sync_div_channel dut_i (
    .dist_clk(dist_clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_en(cfg_en),
    .cfg_code(cfg_code), .sync_n(sync_n), .glob_en(glob_en), .oe_pin(oe_pin),
    .pwr_down(pwr_down), .ch_out(ch_out)
  );

  function automatic int half_of(input logic [7:0] c);
    return (c == 0) ? 1 : int'(c);
  endfunction

  function automatic bit lane_on();
    return cfg_en && glob_en && oe_pin && !pwr_down;
  endfunction

  function automatic bit expect_out(input bit high_phase);
    if (!lane_on()) return 0;
    if (cfg_mode[0]) return m_run && (m_cnt < half_of(cfg_code));
    return high_phase;
  endfunction

  task automatic model_edge();
    bit go, new_h;
    if (!rst_n) begin
      m_prev_sync = 1; m_run = 0; m_cnt = 0;
      for (int k = 0; k < 4; k++) m_hist[k] = 0;
      return;
    end
    go = lane_on() && cfg_mode[0] && !m_hist[3];
    if (!go) begin m_run = 0; m_cnt = 0; end
    else if (!m_run) begin m_run = 1; m_cnt = 0; end
    else if (m_cnt >= 2 * half_of(cfg_code) - 1) m_cnt = 0;
    else m_cnt = m_cnt + 1;
    new_h = sync_n ? 1'b0 : (!m_prev_sync ? 1'b1 : m_hist[0]);
    for (int k = 3; k > 0; k--) m_hist[k] = m_hist[k-1];
    m_hist[0] = new_h;
    m_prev_sync = sync_n;
  endtask

  task automatic check(input bit exp);
    n_tests++;
    if (ch_out !== exp) begin
      n_fail++;
      $display("FAIL %s: ch_out=%0b expected %0b (mode=%0d code=%0d sync_n=%0b)",
               tag, ch_out, exp, cfg_mode, cfg_code, sync_n);
    end
  endtask

  task automatic tick();
    @(posedge dist_clk);
    #1 model_edge();
    #4 check(expect_out(1'b1));
    @(negedge dist_clk);
    #5 check(expect_out(1'b0));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic string auto_tag();
    if (pwr_down) return "R9";
    if (!lane_on()) return "R8";
    if (!cfg_mode[0]) return "R1";
    return "R2";
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    // reset state, divider held (R10)
    tag = "R10";
    ticks(3);
    rst_n = 1'b1;
    cfg_mode = 2'd1; cfg_code = 8'd2; cfg_en = 1'b1;
    ticks(10);
    // three-way enable (R8), restart in high phase after each (R10)
    tag = "R8"; glob_en = 0; ticks(5); glob_en = 1; tag = "R10"; ticks(6);
    tag = "R8"; oe_pin = 0;  ticks(5); oe_pin = 1;  tag = "R10"; ticks(6);
    tag = "R8"; cfg_en = 0;  ticks(5); cfg_en = 1;  tag = "R10"; ticks(6);
    // power-down override (R9)
    tag = "R9"; pwr_down = 1; ticks(5); cfg_mode = 2'd0; ticks(4);
    pwr_down = 0; cfg_mode = 2'd1; tag = "R10"; ticks(4);
    // code zero acts as one (R3)
    tag = "R3"; cfg_code = 8'd0; ticks(12);
    // mode bit decoding (R4)
    tag = "R4"; cfg_mode = 2'd2; ticks(8);
    cfg_mode = 2'd3; cfg_code = 8'd3; ticks(14);
    // one-edge sync glitch ignored (R5)
    tag = "R5"; sync_n = 0; tick(); sync_n = 1; ticks(12);
    // sync hold and aligned release (R6, R7)
    cfg_code = 8'd5;
    tag = "R6"; sync_n = 0; ticks(12);
    tag = "R7"; sync_n = 1; ticks(14);
    // bypass ignores sync (R1)
    tag = "R1"; cfg_mode = 2'd0;
    sync_n = 0; ticks(7); sync_n = 1; ticks(3); sync_n = 0; ticks(2); sync_n = 1; ticks(4);
    // constrained random mix
    for (int i = 0; i < 8000; i++) begin
      if ($urandom_range(199) == 0)
        cfg_code = ($urandom_range(3) == 0) ? 8'($urandom_range(255)) : 8'($urandom_range(6));
      if ($urandom_range(249) == 0) cfg_mode = 2'($urandom_range(3));
      if ($urandom_range(299) == 0) cfg_en = ~cfg_en;
      if ($urandom_range(599) == 0) glob_en = ~glob_en;
      if ($urandom_range(599) == 0) oe_pin = ~oe_pin;
      if ($urandom_range(799) == 0) pwr_down = ~pwr_down;
      if (!cfg_en && $urandom_range(19) == 0) cfg_en = 1;
      if (pwr_down && $urandom_range(19) == 0) pwr_down = 0;
      if (!glob_en && $urandom_range(19) == 0) glob_en = 1;
      if (!oe_pin && $urandom_range(19) == 0) oe_pin = 1;
      if ($urandom_range(29) == 0) sync_n = ~sync_n;
      tag = auto_tag();
      tick();
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule